// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

The block serialises one 32-bit ARINC 429 word onto a bipolar return-to-zero line. The line is modelled as two digital outputs: one drives the line high and one drives it low. With neither asserted, the line sits at null. A host loads the word over a 16-bit bus in two writes. The first write stores the label half. The second write supplies the data half and starts transmission at once. A single holding stage and a busy flag take the place of a word queue.

At the moment it starts, the transmitter latches three per-word options:
- whether bit 32 is replaced by a computed parity bit;
- the parity sense;
- the bit rate, which is the master clock divided by either 10 or 80.

A loopback control sends the waveform to a separate pair of outputs meant for a local receiver. While loopback is active, the external line stays at null.

Top module: `a429_tx`

## Requirements
- R1: After reset, busy_o is low and all four line outputs (line_hi_o, line_lo_o, loop_hi_o, loop_lo_o) are low.
- R2: First half-word mapping (index w[0] = ARINC bit 1):
  - data_i[7] down to data_i[0] become ARINC bits 1 through 8 (bus bit 7 goes to ARINC bit 1);
  - data_i[15:11] become ARINC bits 13 down to 9 (bus bit 11 goes to bit 9);
  - data_i[9] becomes ARINC bit 30;
  - data_i[10] becomes ARINC bit 31;
  - data_i[8] becomes ARINC bit 32.
- R3: In the second half-word, data_i[0] through data_i[15] become ARINC bits 14 through 29.
- R4: Bits are sent in order from ARINC bit 1 to ARINC bit 32.
- R5: With par_en_i low, ARINC bit 32 is sent exactly as loaded.
- R6: With par_en_i high and par_even_i low, bit 32 is replaced so that the 32-bit word has an odd number of ones.
- R7: With par_en_i high and par_even_i high, bit 32 is replaced so that the word has an even number of ones.
- R8: Bit period and bit shape:
  - a bit period is 10 clock cycles when slow_i is low and 80 when it is high;
  - during the first half of the period, the high output is asserted for a one and the low output for a zero;
  - during the second half, neither output is asserted.
- R9: busy_o goes high on the clock edge that samples the starting write (the first bit begins in the same cycle). It stays high for exactly 36 bit periods: 32 data bits plus a gap of 4 null bit times. The line is null throughout the gap.
- R10: A write on wr_lo_i or wr_hi_i while busy_o is high has no effect. It neither changes the word in flight, nor its length, nor the stored first half used by the next word.
- R11: While loop_en_i is high, the waveform appears only on loop_hi_o/loop_lo_o and line_hi_o/line_lo_o stay low. While loop_en_i is low, the loop outputs stay low.
- R12: par_en_i, par_even_i and slow_i are sampled with the starting write. The configuration in effect at start governs the whole word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Host half-word |
| wr_lo_i | input | 1 | Store first (label) half-word |
| wr_hi_i | input | 1 | Store second half-word and start sending |
| par_en_i | input | 1 | Replace bit 32 with parity |
| par_even_i | input | 1 | Parity sense: 0 odd, 1 even |
| slow_i | input | 1 | Rate select: 0 divide by 10, 1 divide by 80 |
| loop_en_i | input | 1 | Route waveform to loop outputs |
| busy_o | output | 1 | Word or inter-word gap in progress |
| line_hi_o | output | 1 | Drive line high |
| line_lo_o | output | 1 | Drive line low |
| loop_hi_o | output | 1 | Loopback high level |
| loop_lo_o | output | 1 | Loopback low level |

## Verification
The checker assumes that wr_lo_i and wr_hi_i are never high in the same cycle, because they share data_i. The bench drives them in separate cycles, always in the order first half, then second half. Under that rule the checker expects:
- no cycle in which both the high and low outputs of a pair are asserted;
- null on every output while idle;
- a rising busy only after a second-half write.

The bench sweeps every combination of parity enable, parity sense and rate over several bit patterns. It rebuilds each received word from the sampled waveform and compares it with a packing and parity computed arithmetically. It changes loopback only while busy_o is low.

// File: rtl/a429_pkg.sv
package a429_pkg;
  localparam int WORD_BITS = 32;
  localparam int HALF_BITS = 16;

  typedef logic [WORD_BITS-1:0] word_t;

  // w[0] is ARINC bit 1
  function automatic word_t pack_word(input logic [HALF_BITS-1:0] lo,
                                      input logic [HALF_BITS-1:0] hi);
    word_t w;
    for (int k = 0; k < 8; k++) w[k] = lo[7-k];
    for (int k = 0; k < 5; k++) w[8+k] = lo[11+k];
    for (int k = 0; k < 16; k++) w[13+k] = hi[k];
    w[29] = lo[9];
    w[30] = lo[10];
    w[31] = lo[8];
    return w;
  endfunction
endpackage

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  localparam int CW = $clog2(DIV_SLOW)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic slow_i,
  output logic drive_o,
  output logic end_o
);
  localparam logic [CW-1:0] LAST_F = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LAST_S = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] HALF_F = CW'(DIV_FAST / 2);
  localparam logic [CW-1:0] HALF_S = CW'(DIV_SLOW / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last, half;

  assign last    = slow_i ? LAST_S : LAST_F;
  assign half    = slow_i ? HALF_S : HALF_F;
  assign end_o   = run_i && (cnt_q == last);
  assign drive_o = run_i && (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (end_o)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/a429_sequencer.sv
module a429_sequencer #(
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS  = 4,
  localparam int TOTAL = WORD_BITS + GAP_BITS,
  localparam int BW    = $clog2(TOTAL)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 bit_end_i,
  output logic                 busy_o,
  output logic                 in_data_o,
  output logic                 bit_o
);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);
  localparam logic [BW-1:0] NDATA    = BW'(WORD_BITS);

  logic                 run_q;
  logic [BW-1:0]        idx_q;
  logic [WORD_BITS-1:0] sh_q;

  assign busy_o    = run_q;
  assign in_data_o = run_q && (idx_q < NDATA);
  assign bit_o     = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
      sh_q  <= word_i;
    end else if (bit_end_i) begin
      sh_q <= {1'b0, sh_q[WORD_BITS-1:1]};
      if (idx_q == LAST_BIT) begin
        run_q <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_tx.sv
module a429_tx
  import a429_pkg::*;
#(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HALF_BITS-1:0] data_i,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic                 par_en_i,
  input  logic                 par_even_i,
  input  logic                 slow_i,
  input  logic                 loop_en_i,
  output logic                 busy_o,
  output logic                 line_hi_o,
  output logic                 line_lo_o,
  output logic                 loop_hi_o,
  output logic                 loop_lo_o
);
  logic [HALF_BITS-1:0] lo_q;
  logic                 slow_q;
  logic                 start, busy, in_data, bit_val, drive, bit_end;
  word_t                raw, word;

  assign start = wr_hi_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      slow_q <= 1'b0;
    end else begin
      if (wr_lo_i && !busy) lo_q <= data_i;
      if (start)            slow_q <= slow_i;
    end
  end

  always_comb begin
    raw  = pack_word(lo_q, data_i);
    word = raw;
    if (par_en_i) word[WORD_BITS-1] = (^raw[WORD_BITS-2:0]) ^ ~par_even_i;
  end

  a429_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .run_i   (busy),
    .slow_i  (slow_q),
    .drive_o (drive),
    .end_o   (bit_end)
  );

  a429_sequencer #(.WORD_BITS(WORD_BITS), .GAP_BITS(GAP_BITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .word_i    (word),
    .bit_end_i (bit_end),
    .busy_o    (busy),
    .in_data_o (in_data),
    .bit_o     (bit_val)
  );

  logic tx_hi, tx_lo;
  assign tx_hi = drive && in_data && bit_val;
  assign tx_lo = drive && in_data && !bit_val;

  assign busy_o    = busy;
  assign line_hi_o = tx_hi && !loop_en_i;
  assign line_lo_o = tx_lo && !loop_en_i;
  assign loop_hi_o = tx_hi && loop_en_i;
  assign loop_lo_o = tx_lo && loop_en_i;
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_hi_i,
  input logic loop_en_i,
  input logic busy_o,
  input logic line_hi_o,
  input logic line_lo_o,
  input logic loop_hi_o,
  input logic loop_lo_o
);
  // R8: a pair never drives both levels at once
  a_r8_no_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_hi_o && line_lo_o) && !(loop_hi_o && loop_lo_o));

  // R9: idle means null everywhere
  a_r9_idle_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(line_hi_o || line_lo_o || loop_hi_o || loop_lo_o));

  // R9: busy only starts from a second-half write
  a_r9_start_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_hi_i));

  // R11: loopback isolates the line
  a_r11_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> !(line_hi_o || line_lo_o));

  a_r11_loop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |-> !(loop_hi_o || loop_lo_o));
endmodule

bind a429_tx a429_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_hi_i   (wr_hi_i),
  .loop_en_i (loop_en_i),
  .busy_o    (busy_o),
  .line_hi_o (line_hi_o),
  .line_lo_o (line_lo_o),
  .loop_hi_o (loop_hi_o),
  .loop_lo_o (loop_lo_o)
);

// File: tb/a429_tx_test.sv
`timescale 1ns/1ps
module a429_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] data = '0;
  logic wr_lo = 0, wr_hi = 0, par_en = 0, par_even = 0, slow = 0, loop_en = 0;
  logic busy, line_hi, line_lo, loop_hi, loop_lo;
  int checks = 0, errors = 0;
  logic [15:0] last_lo;

  always #5 clk = ~clk;

  a429_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .par_en_i(par_en), .par_even_i(par_even), .slow_i(slow), .loop_en_i(loop_en),
    .busy_o(busy), .line_hi_o(line_hi), .line_lo_o(line_lo),
    .loop_hi_o(loop_hi), .loop_lo_o(loop_lo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected word from R2/R3 mapping and R5-R7 parity rule
  function automatic logic [31:0] model(input logic [15:0] lo, input logic [15:0] hi,
                                        input bit pe, input bit ev);
    logic [31:0] w;
    for (int a = 1; a <= 8; a++) w[a-1] = lo[8-a];
    for (int a = 9; a <= 13; a++) w[a-1] = lo[a+2];
    for (int a = 14; a <= 29; a++) w[a-1] = hi[a-14];
    w[29] = lo[9];
    w[30] = lo[10];
    w[31] = lo[8];
    if (pe) w[31] = ev ? ($countones(w[30:0]) % 2 == 1) : ($countones(w[30:0]) % 2 == 0);
    return w;
  endfunction

  // Capture one word; inputs change at negedge. Optional ignored writes mid-word.
  task automatic send(input logic [15:0] lo, input logic [15:0] hi, input bit do_lo,
                      input bit pe, input bit ev, input bit sl, input bit lp,
                      input bit poke, input string tag);
    int div = sl ? 80 : 10;
    int total = 36 * div;
    logic [31:0] rx = '0, exp;
    bit shape_ok = 1, busy_ok = 1, quiet_ok = 1;
    logic [15:0] lo_use = do_lo ? lo : last_lo;
    @(negedge clk);
    loop_en = lp;
    if (do_lo) begin
      data = lo; wr_lo = 1;
      @(negedge clk);
      wr_lo = 0;
      last_lo = lo;
    end
    data = hi; wr_hi = 1; par_en = pe; par_even = ev; slow = sl;
    @(negedge clk);
    wr_hi = 0;
    // R12: flip config right after start; must not affect this word
    par_en = ~pe; par_even = ~ev; slow = ~sl;
    for (int n = 0; n < total; n++) begin
      logic h, l;
      if (n > 0) @(negedge clk);
      if (poke && n == 40) begin data = ~lo; wr_lo = 1; end
      if (poke && n == 41) begin wr_lo = 0; data = ~hi; wr_hi = 1; end
      if (poke && n == 42) wr_hi = 0;
      h = lp ? loop_hi : line_hi;
      l = lp ? loop_lo : line_lo;
      if (lp ? (line_hi || line_lo) : (loop_hi || loop_lo)) quiet_ok = 0;
      if (!busy) busy_ok = 0;
      if (n < 32 * div) begin
        if ((n % div) < div / 2) begin
          if (h == l) shape_ok = 0;
          if ((n % div) == 0) rx[n / div] = h;
        end else if (h || l) shape_ok = 0;
      end else if (h || l) shape_ok = 0;
    end
    @(negedge clk);
    if (busy) busy_ok = 0;
    exp = model(lo_use, hi, pe, ev);
    chk(rx == exp, {tag, " R2 R3 R4 word"}, rx, exp);
    if (pe) chk(($countones(rx) % 2) == (ev ? 0 : 1), ev ? "R7 even parity" : "R6 odd parity",
                $countones(rx), ev ? 0 : 1);
    else chk(rx[31] == lo_use[8], "R5 bit32 as loaded", rx[31], lo_use[8]);
    chk(shape_ok, sl ? "R8 R12 shape div80" : "R8 R12 shape div10", shape_ok, 1);
    chk(busy_ok, "R9 busy 36 bit times", busy_ok, 1);
    chk(quiet_ok, "R11 output routing", quiet_ok, 1);
  endtask

  initial begin
    #500000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pats_lo [4] = '{16'h0001, 16'h8000, 16'h0700, 16'hA5C3};
    logic [15:0] pats_hi [4] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h3C5A};
    last_lo = '0;
    #1;
    chk(!busy && !line_hi && !line_lo && !loop_hi && !loop_lo, "R1 reset state",
        {busy, line_hi, line_lo, loop_hi, loop_lo}, 0);
    #20 rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", busy, 0);
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 4; p++)
        send(pats_lo[p], pats_hi[p], 1, c[0], c[1], c[2], 0, 0, "sweep");
    // R2: walk each first-half bit alone
    for (int b = 0; b < 16; b++) send(16'(1 << b), 16'h0, 1, 0, 0, 0, 0, 0, "R2 walk");
    // R11 loopback
    send(16'h5A3C, 16'h1234, 1, 1, 0, 0, 1, 0, "R11 loop");
    // R10: writes during busy ignored; next word reuses earlier first half
    send(16'h1E2D, 16'h0F0F, 1, 0, 0, 0, 0, 1, "R10 busy write");
    send(16'hFFFF, 16'hC3C3, 0, 0, 0, 0, 0, 0, "R10 held first half");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule